// File: doc/BRIEF.md
# Dual-Bus Flash Read Arbiter with Data Cache

This block sits between two read-only masters and one flash read port that is 64 bits wide. An instruction-fetch port and a data port each issue word reads. A requester raises its request and holds the request and the address until it sees a one-cycle ready pulse, which carries the 64-bit word. Reads that need the flash go out one at a time on the flash master port. When both ports need the flash in the same cycle, the data port is served first. A grant is held until the flash port reports completion, so an access is never cut off.

A small fully associative data cache serves repeated constant reads on the data port without wait states. It has eight lines, each holding four 64-bit words, and each word has its own valid bit. The cache answers only reads made by the processor while the enable input is high, and only for addresses outside a parameterised protected (option-byte) window. Reads that a DMA master makes, reads into that window and reads made while the cache is disabled go to the flash and leave the cache unchanged. A flush input invalidates every line at once.

Top module: `flash_rd_arbiter`

## Requirements
- R1: Every flash access reads one 64-bit word at the 8-byte aligned address `f_addr = {addr[AW-1:3], 3'b000}`. The requester's ready pulse comes in the same cycle as `f_done`, and its data equals `f_rdata`.
- R2: A request is held until a one-cycle ready pulse on its own port. A read that needs the flash gets its ready no earlier than the cycle after the request is first seen.
- R3: When the instruction port and the data port both need the flash in the same idle cycle, the data address is issued to the flash first.
- R4: From the cycle in which `f_req` rises until `f_done`, `f_req` stays high and `f_addr` stays stable. After `f_done`, `f_req` is low for one cycle.
- R5: A processor read (`d_is_dma=0`) of a cacheable address whose word is held in the cache gets `d_ready` in the same cycle as the request, with no flash access, including while an instruction read is in flight. Word validity is tracked per word: a word read earlier does not make the other words of its line hits.
- R6: The cache holds 8 lines of four words, and any line may hold any address. A missing line is placed in the lowest-numbered invalid line if there is one, or else in the least recently used line. A hit or a fill makes that line the most recently used.
- R7: Data reads with `d_is_dma=1` always go to the flash and never allocate a line or a word.
- R8: Data reads with `OPT_BASE <= d_addr < OPT_BASE+OPT_SIZE` always go to the flash and never allocate.
- R9: With `dcache_en=0`, data reads neither hit nor allocate, and the contents already in the cache are kept for when the cache is enabled again. The cache is empty after reset.
- R10: A one-cycle `dcache_flush` pulse invalidates all lines. A fill that completes in the same cycle is discarded.
- R11: Instruction reads always go to the flash and never touch the data cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcache_en | input | 1 | Data cache enable (normally high out of reset) |
| dcache_flush | input | 1 | One-cycle pulse that invalidates the data cache |
| i_req | input | 1 | Instruction read request, held until `i_ready` |
| i_addr | input | AW | Instruction byte address |
| i_ready | output | 1 | Instruction read done, data valid |
| i_rdata | output | 64 | Instruction read data |
| d_req | input | 1 | Data read request, held until `d_ready` |
| d_addr | input | AW | Data byte address |
| d_is_dma | input | 1 | 1 = request from a DMA master, 0 = processor |
| d_ready | output | 1 | Data read done, data valid |
| d_rdata | output | 64 | Data read data |
| f_req | output | 1 | Flash read request, held until `f_done` |
| f_addr | output | AW | Aligned flash word address |
| f_done | input | 1 | Flash read complete, `f_rdata` valid |
| f_rdata | input | 64 | Flash read data |

## Verification
A wrong tag, a stale valid bit or a bad LRU age shows at the ports in the cycle the data port issues its request. A read that should miss answers with zero wait and the wrong word, or a read that should hit raises `f_req` one cycle later and waits. The bench therefore measures the wait of every data read and compares the data with the flash contents. It uses fill sequences whose next victim is known, so an age error shows as a changed hit or miss pattern within a few reads. An arbitration fault shows on `f_addr` in the first busy cycle after a collision.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_INSN = 2'd1,
    ARB_DATA = 2'd2
  } arb_state_t;
endpackage

// File: rtl/fa_lru.sv
// Age-based LRU tracker: ages form a permutation, oldest age = LINES-1.
module fa_lru #(
  parameter int LINES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     touch_en,
  input  logic [$clog2(LINES)-1:0] touch_idx,
  output logic [$clog2(LINES)-1:0] victim_idx
);
  localparam int IDX_W = $clog2(LINES);

  logic [IDX_W-1:0] age_q [LINES];
  logic [IDX_W-1:0] age_d [LINES];

  always_comb begin
    for (int j = 0; j < LINES; j++) begin
      age_d[j] = age_q[j];
      if (touch_en) begin
        if (IDX_W'(j) == touch_idx) age_d[j] = '0;
        else if (age_q[j] < age_q[touch_idx]) age_d[j] = age_q[j] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int j = 0; j < LINES; j++)
      if (age_q[j] == IDX_W'(LINES - 1)) victim_idx = IDX_W'(j);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < LINES; j++) age_q[j] <= IDX_W'(j);
    end else if (touch_en) begin
      for (int j = 0; j < LINES; j++) age_q[j] <= age_d[j];
    end
  end
endmodule

// File: rtl/fa_dcache.sv
// Fully associative data cache, per-word valid bits, word-granular fill.
module fa_dcache #(
  parameter int AW    = 24,
  parameter int LINES = 8,
  parameter int WORDS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-4:0]  lk_word,
  output logic           lk_hit,
  output logic [63:0]    lk_data,
  input  logic           hit_used,
  input  logic           fill_en,
  input  logic [AW-4:0]  fill_word,
  input  logic [63:0]    fill_data,
  input  logic           flush
);
  localparam int OFS_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = AW - 3 - OFS_W;

  logic [TAG_W-1:0] tag_q  [LINES];
  logic [63:0]      data_q [LINES][WORDS];
  logic [WORDS-1:0] wvld_q [LINES];
  logic [LINES-1:0] lvld_q;

  logic [TAG_W-1:0] lk_tag, fl_tag;
  logic [OFS_W-1:0] lk_ofs, fl_ofs;
  logic [IDX_W-1:0] hit_idx, fmatch_idx, inv_idx, victim_idx, fill_idx, touch_idx;
  logic             lk_match, fl_match, any_inv, touch_en;

  assign lk_tag = lk_word[AW-4 -: TAG_W];
  assign lk_ofs = lk_word[OFS_W-1:0];
  assign fl_tag = fill_word[AW-4 -: TAG_W];
  assign fl_ofs = fill_word[OFS_W-1:0];

  always_comb begin
    lk_match   = 1'b0;
    fl_match   = 1'b0;
    any_inv    = 1'b0;
    hit_idx    = '0;
    fmatch_idx = '0;
    inv_idx    = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (lvld_q[i] && tag_q[i] == lk_tag) begin
        lk_match = 1'b1;
        hit_idx  = IDX_W'(i);
      end
      if (lvld_q[i] && tag_q[i] == fl_tag) begin
        fl_match   = 1'b1;
        fmatch_idx = IDX_W'(i);
      end
      if (!lvld_q[i]) begin
        any_inv = 1'b1;
        inv_idx = IDX_W'(i);
      end
    end
  end

  assign lk_hit  = lk_match && wvld_q[hit_idx][lk_ofs];
  assign lk_data = data_q[hit_idx][lk_ofs];

  assign fill_idx  = fl_match ? fmatch_idx : (any_inv ? inv_idx : victim_idx);
  assign touch_en  = fill_en || hit_used;
  assign touch_idx = fill_en ? fill_idx : hit_idx;

  fa_lru #(.LINES(LINES)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .victim_idx(victim_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvld_q <= '0;
      for (int i = 0; i < LINES; i++) wvld_q[i] <= '0;
    end else if (flush) begin
      lvld_q <= '0;
    end else if (fill_en) begin
      lvld_q[fill_idx] <= 1'b1;
      wvld_q[fill_idx] <= (fl_match ? wvld_q[fill_idx] : '0) | (WORDS'(1) << fl_ofs);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[fill_idx]          <= fl_tag;
      data_q[fill_idx][fl_ofs] <= fill_data;
    end
  end
endmodule

// File: rtl/fa_arbiter.sv
// Single-owner flash grant, data port first, held until completion.
module fa_arbiter
  import flash_arb_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          d_need,
  input  logic          i_need,
  input  logic [AW-4:0] d_word,
  input  logic [AW-4:0] i_word,
  input  logic          d_alloc,
  input  logic          f_done,
  output arb_state_t    state_o,
  output logic [AW-4:0] word_o,
  output logic          alloc_o
);
  arb_state_t    state_q, state_d;
  logic [AW-4:0] word_q, word_d;
  logic          alloc_q, alloc_d;
  logic          load;

  always_comb begin
    state_d = state_q;
    word_d  = word_q;
    alloc_d = alloc_q;
    load    = 1'b0;
    unique case (state_q)
      ARB_IDLE: begin
        if (d_need) begin
          state_d = ARB_DATA;
          word_d  = d_word;
          alloc_d = d_alloc;
          load    = 1'b1;
        end else if (i_need) begin
          state_d = ARB_INSN;
          word_d  = i_word;
          alloc_d = 1'b0;
          load    = 1'b1;
        end
      end
      ARB_INSN, ARB_DATA: begin
        if (f_done) state_d = ARB_IDLE;
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      alloc_q <= 1'b0;
    end else if (load) begin
      word_q  <= word_d;
      alloc_q <= alloc_d;
    end
  end

  assign state_o = state_q;
  assign word_o  = word_q;
  assign alloc_o = alloc_q;
endmodule

// File: rtl/flash_rd_arbiter.sv
module flash_rd_arbiter
  import flash_arb_pkg::*;
#(
  parameter int          AW       = 24,
  parameter int          LINES    = 8,
  parameter int          WORDS    = 4,
  parameter int unsigned OPT_BASE = 32'h00FF_0000,
  parameter int unsigned OPT_SIZE = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dcache_en,
  input  logic          dcache_flush,
  input  logic          i_req,
  input  logic [AW-1:0] i_addr,
  output logic          i_ready,
  output logic [63:0]   i_rdata,
  input  logic          d_req,
  input  logic [AW-1:0] d_addr,
  input  logic          d_is_dma,
  output logic          d_ready,
  output logic [63:0]   d_rdata,
  output logic          f_req,
  output logic [AW-1:0] f_addr,
  input  logic          f_done,
  input  logic [63:0]   f_rdata
);
  localparam logic [AW:0] OPT_LO = (AW+1)'(OPT_BASE);
  localparam logic [AW:0] OPT_HI = (AW+1)'(OPT_BASE + OPT_SIZE);

  arb_state_t    state;
  logic [AW-4:0] cur_word;
  logic          cur_alloc;
  logic          in_opt, cacheable, c_hit, d_hit, d_need;
  logic [63:0]   c_data;
  logic [5:0]    unused_lo;

  assign unused_lo = {d_addr[2:0], i_addr[2:0]};

  assign in_opt    = ({1'b0, d_addr} >= OPT_LO) && ({1'b0, d_addr} < OPT_HI);
  assign cacheable = dcache_en && !d_is_dma && !in_opt;
  assign d_hit     = d_req && cacheable && c_hit && (state != ARB_DATA);
  assign d_need    = d_req && !(cacheable && c_hit);

  fa_arbiter #(.AW(AW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_need  (d_need),
    .i_need  (i_req),
    .d_word  (d_addr[AW-1:3]),
    .i_word  (i_addr[AW-1:3]),
    .d_alloc (cacheable),
    .f_done  (f_done),
    .state_o (state),
    .word_o  (cur_word),
    .alloc_o (cur_alloc)
  );

  fa_dcache #(.AW(AW), .LINES(LINES), .WORDS(WORDS)) u_dc (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_word   (d_addr[AW-1:3]),
    .lk_hit    (c_hit),
    .lk_data   (c_data),
    .hit_used  (d_hit),
    .fill_en   ((state == ARB_DATA) && f_done && cur_alloc),
    .fill_word (cur_word),
    .fill_data (f_rdata),
    .flush     (dcache_flush)
  );

  assign f_req   = (state != ARB_IDLE);
  assign f_addr  = {cur_word, 3'b000};
  assign i_ready = (state == ARB_INSN) && f_done;
  assign i_rdata = f_rdata;
  assign d_ready = d_hit || ((state == ARB_DATA) && f_done);
  assign d_rdata = d_hit ? c_data : f_rdata;
endmodule

// File: rtl/flash_rd_arbiter_chk.sv
module flash_rd_arbiter_chk #(
  parameter int          AW       = 24,
  parameter int unsigned OPT_BASE = 32'h00FF_0000,
  parameter int unsigned OPT_SIZE = 32'h0000_1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dcache_en,
  input logic          dcache_flush,
  input logic          i_req,
  input logic          i_ready,
  input logic          d_req,
  input logic [AW-1:0] d_addr,
  input logic          d_is_dma,
  input logic          d_ready,
  input logic          f_req,
  input logic [AW-1:0] f_addr,
  input logic          f_done
);
  logic in_win;
  assign in_win = ({1'b0, d_addr} >= (AW+1)'(OPT_BASE)) &&
                  ({1'b0, d_addr} <  (AW+1)'(OPT_BASE + OPT_SIZE));

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    f_req && !f_done |=> f_req && $stable(f_addr)) else $error("grant dropped"); // R4
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    f_done |=> !f_req) else $error("no gap after done"); // R4
  AST_DATA_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_req) && $past(d_req && d_is_dma && i_req) |->
      f_addr[AW-1:3] == $past(d_addr[AW-1:3])) else $error("insn won"); // R3
  AST_DMA_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    d_ready && d_is_dma |-> f_done) else $error("dma hit"); // R7
  AST_WIN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    d_ready && in_win |-> f_done) else $error("window hit"); // R8
  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    d_ready && !dcache_en |-> f_done) else $error("hit while off"); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dcache_flush) && d_ready |-> f_done) else $error("hit after flush"); // R10
  AST_INSN_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    i_ready |-> f_done) else $error("insn not from flash"); // R11
endmodule

bind flash_rd_arbiter flash_rd_arbiter_chk #(
  .AW(AW), .OPT_BASE(OPT_BASE), .OPT_SIZE(OPT_SIZE)
) u_chk (.*);

// File: tb/flash_rd_arbiter_test.sv
`timescale 1ns/1ps
module flash_rd_arbiter_test;
  localparam int AW = 24;
  localparam logic [AW-1:0] BASE = 24'h00_1000;
  localparam logic [AW-1:0] OPTA = 24'hFF_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dcache_en = 1'b1, dcache_flush = 1'b0;
  logic i_req = 1'b0, d_req = 1'b0, d_is_dma = 1'b0;
  logic [AW-1:0] i_addr = '0, d_addr = '0;
  logic i_ready, d_ready, f_req, f_done = 1'b0;
  logic [63:0] i_rdata, d_rdata, f_rdata = '0;
  logic [AW-1:0] f_addr;

  int n_run = 0, n_fail = 0, wcnt = 0;
  bit done = 0, arm = 0;
  logic [AW-1:0] first_addr;

  always #4 clk = ~clk;  // 125 MHz

  flash_rd_arbiter uut (.*);

  function automatic logic [63:0] mem(input logic [AW-1:0] a);
    logic [AW-1:0] w;
    w = {a[AW-1:3], 3'b000};
    return {8'hA5, w, 8'h3C, ~w};
  endfunction

  function automatic logic [AW-1:0] la(input int line, input int word);
    return BASE + AW'(line * 32 + word * 8);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flash model: random 1..3 cycle latency
  initial forever begin
    @(negedge clk);
    f_done = 1'b0;
    if (f_req) begin
      if (wcnt == 0) wcnt = 1 + int'($urandom % 3);
      wcnt--;
      if (wcnt == 0) begin
        f_done  = 1'b1;
        f_rdata = mem(f_addr);
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (arm && f_req) begin
      first_addr = f_addr;
      arm = 0;
    end
  end

  task automatic d_read(input logic [AW-1:0] a, input bit dma, output logic [63:0] q, output bit hit);
    int n = 0;
    @(negedge clk);
    d_addr = a; d_is_dma = dma; d_req = 1'b1;
    #1;
    while (!d_ready) begin @(negedge clk); #1; n++; end
    q = d_rdata; hit = (n == 0);
    @(posedge clk); #1; d_req = 1'b0;
  endtask

  task automatic i_read(input logic [AW-1:0] a, output logic [63:0] q, output bit hit);
    int n = 0;
    @(negedge clk);
    i_addr = a; i_req = 1'b1;
    #1;
    while (!i_ready) begin @(negedge clk); #1; n++; end
    q = i_rdata; hit = (n == 0);
    @(posedge clk); #1; i_req = 1'b0;
  endtask

  task automatic d_expect(input logic [AW-1:0] a, input bit dma, input bit exp_hit, input string req);
    logic [63:0] q; bit h;
    d_read(a, dma, q, h);
    chk(q == mem(a), {req, " data"}, q, mem(a));
    chk(h == exp_hit, {req, " hit"}, 64'(h), 64'(exp_hit));
  endtask

  task automatic flush_pulse();
    @(negedge clk); dcache_flush = 1'b1;
    @(negedge clk); dcache_flush = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] q; bit h; int seed;
    seed = int'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk(!f_req && !d_ready && !i_ready, "R9 reset idle", 64'(f_req), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    // R9: empty after reset, R5: second read hits, R1 data
    d_expect(la(0, 0), 0, 0, "R9 first read misses");
    d_expect(la(0, 0), 0, 1, "R5 repeat hits");
    // R5 per-word valid
    d_expect(la(0, 1), 0, 0, "R5 other word misses");
    d_expect(la(0, 1), 0, 1, "R5 word filled");
    // R11 instruction never cached
    i_read(la(0, 0), q, h);
    chk(q == mem(la(0, 0)) && !h, "R11 insn from flash", q, mem(la(0, 0)));
    i_read(la(5, 2), q, h);
    i_read(la(5, 2), q, h);
    chk(!h, "R11 insn repeat misses", 64'(h), 64'd0);
    // R7 DMA bypass, no allocate
    d_expect(la(1, 0), 1, 0, "R7 dma read");
    d_expect(la(1, 0), 0, 0, "R7 dma did not allocate");
    d_expect(la(0, 0), 1, 0, "R7 dma never hits");
    // R8 protected window
    d_expect(OPTA + 24'h10, 0, 0, "R8 window read");
    d_expect(OPTA + 24'h10, 0, 0, "R8 window not cached");
    d_expect(OPTA + 24'hFF8, 0, 0, "R8 window top word");
    d_expect(OPTA + 24'h1000, 0, 0, "R8 just above window");
    d_expect(OPTA + 24'h1000, 0, 1, "R8 above window caches");
    // R9 disable
    dcache_en = 1'b0;
    d_expect(la(2, 0), 0, 0, "R9 off read");
    d_expect(la(0, 0), 0, 0, "R9 off no hit");
    dcache_en = 1'b1;
    d_expect(la(2, 0), 0, 0, "R9 off did not allocate");
    d_expect(la(0, 0), 0, 1, "R9 contents kept");
    // R10 flush
    flush_pulse();
    d_expect(la(0, 0), 0, 0, "R10 flushed");
    // R6 LRU
    flush_pulse();
    for (int l = 0; l < 8; l++) d_expect(la(l, 0), 0, 0, "R6 fill");
    d_expect(la(0, 0), 0, 1, "R6 touch line0");
    d_expect(la(8, 0), 0, 0, "R6 new line");
    d_expect(la(0, 0), 0, 1, "R6 recent kept");
    d_expect(la(1, 0), 0, 0, "R6 lru evicted");
    d_expect(la(3, 0), 0, 1, "R6 line3 kept");
    d_expect(la(2, 0), 0, 0, "R6 second victim");
    // R3 priority with R5 hit during insn access
    arm = 1;
    fork
      d_expect(la(9, 3), 1, 0, "R3 data side");
      begin
        i_read(la(10, 1), q, h);
        chk(q == mem(la(10, 1)), "R3 insn data", q, mem(la(10, 1)));
      end
    join
    chk(first_addr == la(9, 3), "R3 data granted first", 64'(first_addr), 64'(la(9, 3)));
    fork
      begin
        i_read(la(11, 0), q, h);
        chk(q == mem(la(11, 0)), "R2 insn data", q, mem(la(11, 0)));
      end
      begin
        @(negedge clk); @(negedge clk);
        d_expect(la(0, 0), 0, 1, "R5 hit while insn busy");
      end
    join
    // R10 flush in same cycle as fill completion
    @(negedge clk);
    d_addr = la(12, 0); d_is_dma = 1'b0; d_req = 1'b1;
    #1;
    while (!d_ready) begin @(negedge clk); #1; end
    dcache_flush = 1'b1;
    @(posedge clk); #1; d_req = 1'b0;
    @(negedge clk); dcache_flush = 1'b0;
    d_expect(la(12, 0), 0, 0, "R10 fill with flush dropped");

    // random phase
    fork
      for (int k = 0; k < 200; k++) begin
        logic [AW-1:0] a; bit dma, cab;
        a = (($urandom % 6) == 0) ? OPTA + AW'(($urandom % 8) * 8)
                                  : la(int'($urandom % 12), int'($urandom % 4));
        dma = (($urandom % 4) == 0);
        dcache_en = (($urandom % 5) != 0);
        cab = dcache_en && !dma && (a < OPTA);
        d_read(a, dma, q, h);
        chk(q == mem(a), "R1 random data", q, mem(a));
        if (!cab) chk(!h, "R7 R8 R9 random bypass", 64'(h), 64'd0);
        else begin
          d_read(a, 0, q, h);
          chk(h && q == mem(a), "R5 random rehit", q, mem(a));
        end
      end
      for (int k = 0; k < 150; k++) begin
        logic [AW-1:0] a; logic [63:0] qi; bit hi;
        a = la(int'($urandom % 16), int'($urandom % 4));
        i_read(a, qi, hi);
        chk(qi == mem(a) && !hi, "R2 R11 random insn", qi, mem(a));
        repeat (int'($urandom % 3)) @(negedge clk);
      end
    join
    dcache_en = 1'b1;

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule